// File: doc/BRIEF.md
# Tap-Parameterised Galois Shift Generator

This block is a Galois-form linear-feedback shift register. A single compile-time tap vector sets its whole structure. Each bit of the vector stands for one power of the feedback polynomial. A set bit places an XOR gate in front of that stage. The register has one stage for each power below the highest set bit. On every enabled clock edge the top stage's bit becomes the feedback bit. That bit enters stage 0 and is XORed into every higher tapped stage as the register shifts up.

A serial data input is XORed with the top stage to form the feedback bit. This lets the block accumulate a CRC remainder or act as a self-synchronising scrambler core. With that input held low, the block is a free-running pseudo-random bit generator. Its outputs are the parallel state and a serial bit, which is the top stage before the update. A parallel seed can be loaded at any time. A synchronous reset puts an all-ones seed into the register, so a primitive polynomial starts on its maximal cycle.

Top module: `galois_shift_gen`

## Requirements
- R1: When `rst` is high at a rising clock edge, `state` becomes all ones on that edge. This takes priority over every other input.
- R2: When `load` is high and `rst` is low at a rising edge, `state` takes the value of `seed` on that edge, whatever the value of `en`.
- R3: When `rst`, `load` and `en` are all low at a rising edge, `state` keeps its value.
- R4: On an enabled shift, stage 0 receives the feedback bit. Each stage k above 0 receives stage k-1, XORed with the feedback bit when bit k of `TAPS` is set. Bit `STAGES` of `TAPS` must be set, because the highest set bit is the polynomial degree.
- R5: The feedback bit is the top stage `state[STAGES-1]` XORed with `din`.
- R6: `dout` equals the top stage `state[STAGES-1]` as held before the coming edge.
- R7: With the default taps (x^8+x^4+x^3+x^2+1, `TAPS` = 9'h11D) and `din` low, the sequence started from a nonzero seed returns to that seed after exactly 255 shifts and not sooner.
- R8: An all-zero `state` with `din` low stays all zero across enabled shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to all ones |
| en | input | 1 | Advance the register by one step |
| load | input | 1 | Load `seed` into the state |
| seed | input | STAGES | Parallel seed value |
| din | input | 1 | Serial data XORed into the feedback |
| state | output | STAGES | Current register contents |
| dout | output | 1 | Serial output, the top stage before update |

## Verification
A wrong tap or shift connection corrupts `state` on the first enabled edge after it matters, and `dout` shows the same error one or more steps later as the bad bit moves up. The bench loads every one of the 256 seeds and shifts once with `din` at both values. This exposes any wrong stage, tap or feedback term within a single cycle. A full 255-step run confirms the period, and an all-zero run shows the lock-up state.

// File: rtl/galois_shift_gen.sv
`timescale 1ns/1ps
module galois_shift_gen #(
  parameter int STAGES = 8,
  parameter logic [STAGES:0] TAPS = 9'h11D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              load,
  input  logic [STAGES-1:0] seed,
  input  logic              din,
  output logic [STAGES-1:0] state,
  output logic              dout
);

  logic              fb;
  logic [STAGES-1:0] nxt;

  if (TAPS[STAGES] != 1'b1) begin : g_bad_degree
    $error("TAPS bit STAGES must be set");
  end

  assign fb   = state[STAGES-1] ^ din;
  assign dout = state[STAGES-1];

  assign nxt[0] = fb;
  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    if (TAPS[k]) begin : g_tap
      assign nxt[k] = state[k-1] ^ fb;
    end else begin : g_plain
      assign nxt[k] = state[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       state <= '1;
    else if (load) state <= seed;
    else if (en)   state <= nxt;
  end

  assert_reset_ones_R1: assert property (@(posedge clk) rst |=> state == '1);
  assert_load_seed_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> state == $past(seed));
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!load && !en) |=> $stable(state));
  assert_stage0_fb_R5: assert property (@(posedge clk) disable iff (rst)
    (!load && en) |=> state[0] == $past(dout ^ din));
  assert_zero_lock_R8: assert property (@(posedge clk) disable iff (rst)
    (!load && en && !din && state == '0) |=> state == '0);

endmodule

// File: tb/galois_shift_gen_bench.sv
`timescale 1ns/1ps
module galois_shift_gen_bench;
  localparam int W = 8;
  localparam logic [W:0] TP = 9'h11D;

  logic clk = 0, rst = 1, en = 0, load = 0, din = 0;
  logic [W-1:0] seed = '0;
  logic [W-1:0] state;
  logic dout;
  int checks = 0, failures = 0;
  logic [W-1:0] model;

  galois_shift_gen #(.STAGES(W), .TAPS(TP)) u_galois_shift_gen (
    .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed),
    .din(din), .state(state), .dout(dout));

  always #2 clk = ~clk;

  function automatic logic [W-1:0] ref_next(logic [W-1:0] s, logic d);
    logic f;
    f = s[W-1] ^ d;
    return {s[W-2:0], 1'b0} ^ (f ? TP[W-1:0] : '0);
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(logic r, logic e, logic l, logic [W-1:0] sd, logic d, string req);
    rst = r; en = e; load = l; seed = sd; din = d;
    if (!r) chk("R6 dout", {{(W-1){1'b0}}, dout}, {{(W-1){1'b0}}, model[W-1]});
    if (r)      model = '1;
    else if (l) model = sd;
    else if (e) model = ref_next(model, d);
    @(posedge clk); #1;
    chk(req, state, model);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int period;
    model = '1;
    @(negedge clk);
    cyc(1, 0, 0, '0, 0, "R1 reset");
    // R3 hold with enable low
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 8'h33, 1, "R3 hold");
    // R2 load wins over enable
    cyc(0, 1, 1, 8'h5A, 1, "R2 load");
    cyc(0, 0, 1, 8'hC3, 0, "R2 load no en");
    // R4/R5 exhaustive single step from each seed, both din values
    for (int v = 0; v < 256; v++)
      for (int d = 0; d < 2; d++) begin
        cyc(0, 0, 1, v[W-1:0], 0, "R2 load sweep");
        cyc(0, 1, 0, '0, d[0], "R4 R5 step");
      end
    // R7 period from the reset seed
    cyc(1, 0, 0, '0, 0, "R1 reset again");
    period = 0;
    for (int i = 0; i < 300; i++) begin
      cyc(0, 1, 0, '0, 0, "R7 sequence");
      period++;
      if (state == 8'hFF) break;
    end
    chk("R7 period", period[W-1:0], 8'd255);
    // R5 scrambler pattern on din
    for (int i = 0; i < 40; i++) cyc(0, 1, 0, '0, ((i * 7) % 3) == 0, "R5 din pattern");
    // R1 reset mid-run
    cyc(1, 1, 1, 8'h12, 1, "R1 reset priority");
    // R8 zero lock-up
    cyc(0, 0, 1, 8'h00, 0, "R2 load zero");
    for (int i = 0; i < 20; i++) cyc(0, 1, 0, '0, 0, "R8 zero lock");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule